// File: doc/BRIEF.md
# Register List Save/Restore Sequencer

This block saves a chosen group of registers to a memory stack, or restores such a group from it, as one operation. It holds a sixteen-entry register file: eight data registers, d0 to d7 at indices 0 to 7, and eight address registers, a0 to a7 at indices 8 to 15. A single start pulse supplies three things: a 16-bit selection mask, a direction (save or restore) and a starting stack pointer. The block then issues one word transfer for each selected register, in a fixed order, on a simple synchronous memory port. It ends with one update of the stack pointer result and a one-cycle done pulse.

The direction changes two things: how mask bits map to registers, and the order in which the registers are visited. These two reversals make a save followed by a restore of the mirrored mask put every register back where it came from. A separate port gives direct access to the register file so that its contents can be loaded and observed. That port accepts writes only while the sequencer is idle.

Top module: `regsave_seq`

## Requirements
- R1: In save mode, mask bit i selects register index i. In restore mode, mask bit i selects register index 15-i. Example: a save with mask 0x010f selects d0..d3 and a0 and makes exactly five writes, and a restore with mask 0xf080 selects the same five registers.
- R2: In save mode (`pop_mode`=0), the selected registers are written in descending index order (a7 down to a0, then d7 down to d0). Each write carries that register's current contents, and `mem_we` is 1.
- R3: In restore mode (`pop_mode`=1), the selected registers are read in ascending index order (d0 up to d7, then a0 up to a7) with `mem_we` 0. The read data is written into the register in the cycle the read is accepted.
- R4: In save mode, the pointer is lowered by STEP (4) before each write, and the write goes to the lowered pointer.
- R5: In restore mode, each read goes to the current pointer, and the pointer is raised by STEP after the read is accepted.
- R6: A transfer is accepted on a rising clock edge where `mem_req` and `mem_ready` are both 1. Until then, `mem_req`, `mem_addr` and `mem_we` hold steady.
- R7: `done` is high for exactly the one cycle after the final accepted transfer. In that cycle `mem_req` is 0 and `sp_out` shows the final pointer: `sp_in` − n·STEP for a save, `sp_in` + n·STEP for a restore.
- R8: An all-zero mask produces no memory request. `done` rises the cycle after start, with `sp_out` equal to `sp_in`.
- R9: A start pulse that arrives while transfers are in progress is ignored.
- R10: While the sequencer is idle, a write on `rf_we` updates the register at `rf_waddr` at the next edge. `rf_rdata` shows the register at `rf_raddr` combinationally. Host writes made while transfers are in progress have no effect.
- R11: After reset, `done` is 0, `mem_req` is 0 and `sp_out` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin an operation (used only when idle) |
| pop_mode | input | 1 | 0 = save (predecrement), 1 = restore (postincrement) |
| reg_mask | input | 16 | Register selection mask |
| sp_in | input | 32 | Starting stack pointer |
| done | output | 1 | One-cycle completion pulse |
| sp_out | output | 32 | Final stack pointer |
| mem_req | output | 1 | Memory transfer request |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_addr | output | 32 | Transfer address |
| mem_wdata | output | 32 | Write data |
| mem_rdata | input | 32 | Read data, sampled when the read is accepted |
| mem_ready | input | 1 | Memory accepts the current transfer |
| rf_we | input | 1 | Host register write enable |
| rf_waddr | input | 4 | Host write index |
| rf_wdata | input | 32 | Host write data |
| rf_raddr | input | 4 | Host read index |
| rf_rdata | output | 32 | Host read data |

## Verification
The main sequence is exercised with the five-register example mask in both directions, a full mask, a single-register mask and an empty mask. This shows separately whether the bit mapping is mirrored, whether the visiting order is reversed, and whether the pointer arithmetic scales with the number of registers. Each list runs with memory always ready and with randomly stalled ready, which distinguishes correct request holding from transfers that advance early. Restoring after the registers have been clobbered shows that read data lands in the right registers. Stray start pulses and host writes issued mid-sequence show that both are ignored.

// File: rtl/regsave_pkg.sv
package regsave_pkg;
  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_RUN  = 1'b1
  } seq_state_e;

  typedef enum logic {
    DIR_SAVE    = 1'b0,
    DIR_RESTORE = 1'b1
  } seq_dir_e;
endpackage

// File: rtl/regsave_map.sv
module regsave_map #(
  parameter int NREG = 16
) (
  input  logic            restore,
  input  logic [NREG-1:0] mask,
  output logic [NREG-1:0] sel
);
  logic [NREG-1:0] mirrored;

  for (genvar g = 0; g < NREG; g++) begin : g_mirror
    assign mirrored[g] = mask[NREG-1-g];
  end

  assign sel = restore ? mirrored : mask;
endmodule

// File: rtl/regsave_pick.sv
module regsave_pick #(
  parameter int NREG = 16,
  localparam int IW = $clog2(NREG)
) (
  input  logic [NREG-1:0] pend,
  input  logic            restore,
  output logic [IW-1:0]   idx,
  output logic            last
);
  logic [IW-1:0] hi_idx;
  logic [IW-1:0] lo_idx;
  int unsigned   cnt;

  always_comb begin
    hi_idx = '0;
    for (int r = 0; r < NREG; r++) begin
      if (pend[r]) hi_idx = IW'(r);
    end
  end

  always_comb begin
    lo_idx = '0;
    for (int r = NREG - 1; r >= 0; r--) begin
      if (pend[r]) lo_idx = IW'(r);
    end
  end

  always_comb begin
    cnt = 0;
    for (int r = 0; r < NREG; r++) begin
      cnt = cnt + {31'd0, pend[r]};
    end
  end

  assign idx  = restore ? lo_idx : hi_idx;
  assign last = (cnt == 1);
endmodule

// File: rtl/regsave_rf.sv
module regsave_rf #(
  parameter int NREG = 16,
  parameter int DW   = 32,
  localparam int IW = $clog2(NREG)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [IW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [IW-1:0] raddr_a,
  output logic [DW-1:0] rdata_a,
  input  logic [IW-1:0] raddr_b,
  output logic [DW-1:0] rdata_b
);
  logic [DW-1:0] regs_q [NREG];

  always_ff @(posedge clk) begin
    if (we) regs_q[waddr] <= wdata;
  end

  assign rdata_a = regs_q[raddr_a];
  assign rdata_b = regs_q[raddr_b];
endmodule

// File: rtl/regsave_ctrl.sv
module regsave_ctrl
  import regsave_pkg::*;
#(
  parameter int NREG = 16,
  parameter int AW   = 32,
  parameter int STEP = 4,
  localparam int IW = $clog2(NREG)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start,
  input  logic            restore_in,
  input  logic [NREG-1:0] sel,
  input  logic [AW-1:0]   sp_in,
  input  logic [IW-1:0]   cur_idx,
  input  logic            cur_last,
  input  logic            mem_ready,
  output logic [NREG-1:0] pend,
  output logic            running,
  output logic            restore,
  output logic [AW-1:0]   mem_addr,
  output logic            load_en,
  output logic            done,
  output logic [AW-1:0]   sp_out
);
  seq_state_e      state_q, state_d;
  seq_dir_e        dir_q, dir_d;
  logic [NREG-1:0] pend_q, pend_d;
  logic [AW-1:0]   ptr_q, ptr_d;
  logic [AW-1:0]   spo_q, spo_d;
  logic            done_q, done_d;
  logic [AW-1:0]   ptr_step;
  logic            accept;

  assign ptr_step = (dir_q == DIR_RESTORE) ? ptr_q + AW'(STEP) : ptr_q - AW'(STEP);
  assign accept   = (state_q == ST_RUN) && mem_ready;

  always_comb begin
    state_d = state_q;
    dir_d   = dir_q;
    pend_d  = pend_q;
    ptr_d   = ptr_q;
    spo_d   = spo_q;
    done_d  = 1'b0;
    case (state_q)
      ST_IDLE: begin
        if (start) begin
          pend_d = sel;
          dir_d  = restore_in ? DIR_RESTORE : DIR_SAVE;
          ptr_d  = sp_in;
          if (sel == '0) begin
            done_d = 1'b1;
            spo_d  = sp_in;
          end else begin
            state_d = ST_RUN;
          end
        end
      end
      ST_RUN: begin
        if (mem_ready) begin
          pend_d = pend_q & ~(NREG'(1) << cur_idx);
          ptr_d  = ptr_step;
          if (cur_last) begin
            state_d = ST_IDLE;
            done_d  = 1'b1;
            spo_d   = ptr_step;
          end
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      dir_q   <= DIR_SAVE;
      pend_q  <= '0;
      ptr_q   <= '0;
      spo_q   <= '0;
      done_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      dir_q   <= dir_d;
      pend_q  <= pend_d;
      ptr_q   <= ptr_d;
      spo_q   <= spo_d;
      done_q  <= done_d;
    end
  end

  assign pend     = pend_q;
  assign running  = (state_q == ST_RUN);
  assign restore  = (dir_q == DIR_RESTORE);
  assign mem_addr = (dir_q == DIR_RESTORE) ? ptr_q : ptr_step;
  assign load_en  = accept && (dir_q == DIR_RESTORE);
  assign done     = done_q;
  assign sp_out   = spo_q;
endmodule

// File: rtl/regsave_seq.sv
module regsave_seq #(
  parameter int NREG = 16,
  parameter int DW   = 32,
  parameter int AW   = 32,
  parameter int STEP = 4,
  localparam int IW = $clog2(NREG)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start,
  input  logic            pop_mode,
  input  logic [NREG-1:0] reg_mask,
  input  logic [AW-1:0]   sp_in,
  output logic            done,
  output logic [AW-1:0]   sp_out,
  output logic            mem_req,
  output logic            mem_we,
  output logic [AW-1:0]   mem_addr,
  output logic [DW-1:0]   mem_wdata,
  input  logic [DW-1:0]   mem_rdata,
  input  logic            mem_ready,
  input  logic            rf_we,
  input  logic [IW-1:0]   rf_waddr,
  input  logic [DW-1:0]   rf_wdata,
  input  logic [IW-1:0]   rf_raddr,
  output logic [DW-1:0]   rf_rdata
);
  logic            rst_meta_q, rst_q_n;
  logic [NREG-1:0] sel;
  logic [NREG-1:0] pend;
  logic [IW-1:0]   cur_idx;
  logic            cur_last;
  logic            running;
  logic            restore;
  logic            load_en;
  logic            wr_en;
  logic [IW-1:0]   wr_addr;
  logic [DW-1:0]   wr_data;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_q_n    <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_q_n    <= rst_meta_q;
    end
  end

  regsave_map #(.NREG(NREG)) u_map (
    .restore (pop_mode),
    .mask    (reg_mask),
    .sel     (sel)
  );

  regsave_pick #(.NREG(NREG)) u_pick (
    .pend    (pend),
    .restore (restore),
    .idx     (cur_idx),
    .last    (cur_last)
  );

  regsave_ctrl #(.NREG(NREG), .AW(AW), .STEP(STEP)) u_ctrl (
    .clk        (clk),
    .rst_n      (rst_q_n),
    .start      (start),
    .restore_in (pop_mode),
    .sel        (sel),
    .sp_in      (sp_in),
    .cur_idx    (cur_idx),
    .cur_last   (cur_last),
    .mem_ready  (mem_ready),
    .pend       (pend),
    .running    (running),
    .restore    (restore),
    .mem_addr   (mem_addr),
    .load_en    (load_en),
    .done       (done),
    .sp_out     (sp_out)
  );

  assign wr_en   = load_en | (rf_we & ~running);
  assign wr_addr = load_en ? cur_idx : rf_waddr;
  assign wr_data = load_en ? mem_rdata : rf_wdata;

  regsave_rf #(.NREG(NREG), .DW(DW)) u_rf (
    .clk     (clk),
    .we      (wr_en),
    .waddr   (wr_addr),
    .wdata   (wr_data),
    .raddr_a (cur_idx),
    .rdata_a (mem_wdata),
    .raddr_b (rf_raddr),
    .rdata_b (rf_rdata)
  );

  assign mem_req = running;
  assign mem_we  = running & ~restore;
endmodule

// File: rtl/regsave_chk.sv
module regsave_chk #(
  parameter int NREG = 16,
  parameter int AW   = 32,
  parameter int STEP = 4
) (
  input logic            clk,
  input logic            rst_ok,
  input logic            start,
  input logic [NREG-1:0] reg_mask,
  input logic [AW-1:0]   sp_in,
  input logic            done,
  input logic [AW-1:0]   sp_out,
  input logic            mem_req,
  input logic            mem_we,
  input logic [AW-1:0]   mem_addr,
  input logic            mem_ready
);
  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_ok)
    mem_req && !mem_ready |=> mem_req && $stable(mem_addr) && $stable(mem_we)); // R6

  AST_SAVE_STEP: assert property (@(posedge clk) disable iff (!rst_ok)
    mem_req && mem_ready && mem_we |=> !mem_req || (mem_addr == $past(mem_addr) - AW'(STEP))); // R4

  AST_RESTORE_STEP: assert property (@(posedge clk) disable iff (!rst_ok)
    mem_req && mem_ready && !mem_we |=> !mem_req || (mem_addr == $past(mem_addr) + AW'(STEP))); // R5

  AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_ok)
    done |-> !mem_req); // R7

  AST_SAVE_FINAL_SP: assert property (@(posedge clk) disable iff (!rst_ok)
    mem_req && mem_ready && mem_we |=> !done || (sp_out == $past(mem_addr))); // R7

  AST_RESTORE_FINAL_SP: assert property (@(posedge clk) disable iff (!rst_ok)
    mem_req && mem_ready && !mem_we |=> !done || (sp_out == $past(mem_addr) + AW'(STEP))); // R7

  AST_EMPTY_LIST: assert property (@(posedge clk) disable iff (!rst_ok)
    start && !mem_req && (reg_mask == '0) |=> done && !mem_req && (sp_out == $past(sp_in))); // R8
endmodule

bind regsave_seq regsave_chk #(.NREG(NREG), .AW(AW), .STEP(STEP)) u_chk (
  .clk       (clk),
  .rst_ok    (rst_q_n),
  .start     (start),
  .reg_mask  (reg_mask),
  .sp_in     (sp_in),
  .done      (done),
  .sp_out    (sp_out),
  .mem_req   (mem_req),
  .mem_we    (mem_we),
  .mem_addr  (mem_addr),
  .mem_ready (mem_ready)
);

// File: tb/regsave_seq_bench.sv
`timescale 1ns/1ps
module regsave_seq_bench;
  localparam int STEP = 4;

  logic        clk;
  logic        rst_n;
  logic        start;
  logic        pop_mode;
  logic [15:0] reg_mask;
  logic [31:0] sp_in;
  logic        done;
  logic [31:0] sp_out;
  logic        mem_req;
  logic        mem_we;
  logic [31:0] mem_addr;
  logic [31:0] mem_wdata;
  logic [31:0] mem_rdata;
  logic        mem_ready;
  logic        rf_we;
  logic [3:0]  rf_waddr;
  logic [31:0] rf_wdata;
  logic [3:0]  rf_raddr;
  logic [31:0] rf_rdata;

  regsave_seq u_regsave_seq (
    .clk(clk), .rst_n(rst_n), .start(start), .pop_mode(pop_mode),
    .reg_mask(reg_mask), .sp_in(sp_in), .done(done), .sp_out(sp_out),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .mem_ready(mem_ready),
    .rf_we(rf_we), .rf_waddr(rf_waddr), .rf_wdata(rf_wdata),
    .rf_raddr(rf_raddr), .rf_rdata(rf_rdata)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  bit finished = 0;

  // reference model state
  bit          m_busy;
  bit          m_pop;
  bit          m_done;
  logic [31:0] m_ptr;
  logic [31:0] m_sp;
  logic [31:0] m_rf [16];
  int          m_q [$];
  logic [31:0] bmem [logic [31:0]];
  int          n_xfer;
  bit          rdy_random;

  task automatic check(string tag, logic [63:0] got, logic [63:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h t=%0t", tag, got, exp, $time);
    end
  endtask

  function automatic logic [31:0] exp_addr();
    return m_pop ? m_ptr : m_ptr - STEP;
  endfunction

  // One cycle: inputs are set by the caller at the negedge before this call.
  task automatic tick();
    logic [31:0] a;
    mem_ready = rdy_random ? ($urandom_range(0, 3) != 0) : 1'b1;
    a = exp_addr();
    if (m_busy && m_pop) mem_rdata = bmem.exists(a) ? bmem[a] : (32'h5a5a0000 ^ a);
    else mem_rdata = 32'h0;
    #1;
    check("R6 mem_req", {63'd0, mem_req}, {63'd0, m_busy});
    if (m_busy) begin
      check(m_pop ? "R5 mem_addr" : "R4 mem_addr", {32'd0, mem_addr}, {32'd0, a});
      check(m_pop ? "R3 mem_we" : "R2 mem_we", {63'd0, mem_we}, {63'd0, !m_pop});
      if (!m_pop) check("R2 mem_wdata", {32'd0, mem_wdata}, {32'd0, m_rf[m_q[0]]});
    end
    check("R7 done", {63'd0, done}, {63'd0, m_done});
    if (m_done) check("R7 sp_out", {32'd0, sp_out}, {32'd0, m_sp});
    @(posedge clk);
    begin
      bit was_busy;
      was_busy = m_busy;
      m_done = 0;
      if (m_busy) begin
        if (mem_ready) begin
          if (m_pop) m_rf[m_q[0]] = mem_rdata;
          else bmem[a] = m_rf[m_q[0]];
          m_ptr = m_pop ? m_ptr + STEP : m_ptr - STEP;
          void'(m_q.pop_front());
          n_xfer++;
          if (m_q.size() == 0) begin
            m_busy = 0;
            m_done = 1;
            m_sp = m_ptr;
          end
        end
      end else if (start) begin
        m_pop = pop_mode;
        m_ptr = sp_in;
        m_q.delete();
        if (pop_mode) begin
          for (int r = 0; r < 16; r++) if (reg_mask[15 - r]) m_q.push_back(r);
        end else begin
          for (int r = 15; r >= 0; r--) if (reg_mask[r]) m_q.push_back(r);
        end
        if (m_q.size() == 0) begin
          m_done = 1;
          m_sp = sp_in;
        end else m_busy = 1;
      end
      if (rf_we && !was_busy) m_rf[rf_waddr] = rf_wdata;
    end
    @(negedge clk);
  endtask

  task automatic host_write(int r, logic [31:0] v);
    rf_we = 1; rf_waddr = 4'(r); rf_wdata = v;
    tick();
    rf_we = 0;
  endtask

  task automatic host_read(string tag, int r, logic [31:0] v);
    rf_raddr = 4'(r);
    #1;
    check(tag, {32'd0, rf_rdata}, {32'd0, v});
  endtask

  task automatic run_list(bit pop, logic [15:0] mask, logic [31:0] sp);
    start = 1; pop_mode = pop; reg_mask = mask; sp_in = sp;
    n_xfer = 0;
    tick();
    start = 0;
    while (m_busy) tick();
    tick();
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000 && !finished) begin
      finished = 1;
      errors++;
      checks++;
      $display("FAIL R7 watchdog actual=hung expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  logic [31:0] orig [16];

  initial begin
    rst_n = 0; start = 0; pop_mode = 0; reg_mask = 0; sp_in = 0;
    mem_rdata = 0; mem_ready = 0; rf_we = 0; rf_waddr = 0; rf_wdata = 0; rf_raddr = 0;
    m_busy = 0; m_pop = 0; m_done = 0; m_ptr = 0; m_sp = 0; n_xfer = 0; rdy_random = 0;
    for (int r = 0; r < 16; r++) m_rf[r] = 'x;
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (3) @(negedge clk);
    // R11 reset state
    check("R11 done", {63'd0, done}, 64'd0);
    check("R11 mem_req", {63'd0, mem_req}, 64'd0);
    check("R11 sp_out", {32'd0, sp_out}, 64'd0);

    // R10 load all registers while idle
    for (int r = 0; r < 16; r++) begin
      orig[r] = 32'h1000_0000 + 32'(r) * 32'h0101_0111;
      host_write(r, orig[r]);
    end
    for (int r = 0; r < 16; r++) host_read("R10 idle write", r, orig[r]);

    // R1 save with five-register example mask
    run_list(0, 16'h010f, 32'h0000_1000);
    check("R1 save count", 64'(n_xfer), 64'd5);
    check("R1 save sp", {32'd0, sp_out}, 64'h0000_0fec);

    // clobber, then restore with mirrored mask, stalled memory
    for (int r = 0; r < 4; r++) host_write(r, 32'hdead_0000 + 32'(r));
    host_write(8, 32'hdead_0008);
    rdy_random = 1;
    run_list(1, 16'hf080, 32'h0000_0fec);
    check("R1 restore count", 64'(n_xfer), 64'd5);
    for (int r = 0; r < 16; r++) host_read("R3 restored", r, orig[r]);

    // full list both ways with stalls
    run_list(0, 16'hffff, 32'h0000_2000);
    check("R4 full save sp", {32'd0, sp_out}, 64'h0000_1fc0);
    for (int r = 0; r < 16; r++) host_write(r, 32'hbeef_0000 + 32'(r));
    run_list(1, 16'hffff, 32'h0000_1fc0);
    check("R5 full restore sp", {32'd0, sp_out}, 64'h0000_2000);
    for (int r = 0; r < 16; r++) host_read("R3 full restore", r, orig[r]);

    // R8 empty list both directions
    rdy_random = 0;
    run_list(0, 16'h0000, 32'h0000_3330);
    check("R8 empty save count", 64'(n_xfer), 64'd0);
    check("R8 empty sp", {32'd0, sp_out}, 64'h0000_3330);
    run_list(1, 16'h0000, 32'h0000_4440);
    check("R8 empty restore sp", {32'd0, sp_out}, 64'h0000_4440);

    // single register restore: bit0 in restore mode selects a7
    host_write(15, 32'h0);
    run_list(1, 16'h0001, 32'h0000_1fc0);
    host_read("R1 single restore a7", 15, orig[0]);

    // R9 start while busy is ignored
    start = 1; pop_mode = 0; reg_mask = 16'h0003; sp_in = 32'h0000_5000; n_xfer = 0;
    rdy_random = 1;
    tick();
    start = 1; pop_mode = 1; reg_mask = 16'hffff; sp_in = 32'h0000_9000;
    tick();
    start = 0;
    while (m_busy) tick();
    tick();
    check("R9 transfers", 64'(n_xfer), 64'd2);
    check("R9 sp", {32'd0, sp_out}, 64'h0000_4ff8);

    // R10 host write while busy is ignored
    rdy_random = 0;
    host_write(5, 32'h5555_0005);
    start = 1; pop_mode = 0; reg_mask = 16'h8001; sp_in = 32'h0000_6000; n_xfer = 0;
    tick();
    start = 0;
    rf_we = 1; rf_waddr = 4'd5; rf_wdata = 32'hbad0_0005;
    while (m_busy) tick();
    rf_we = 0;
    tick();
    host_read("R10 busy write ignored", 5, 32'h5555_0005);
    check("R2 two writes", 64'(n_xfer), 64'd2);

    repeat (2) tick();
    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule